// File: doc/BRIEF.md
# Memory-Mapped Character LCD Bridge

This block sits between the external data bus of a small 8-bit microcontroller and a parallel character LCD controller. It watches the high address byte, the active-low read and write strobes and the processor data bus. An access that lands in the LCD window becomes a single enable pulse on the display side, with correct timing. Firmware then reaches the display with ordinary external-memory moves and never toggles the enable line itself.

The two lowest bits of the high address byte choose the register-select and direction lines. The bridge holds these lines stable for a programmable number of clocks before it raises the enable. It keeps the enable high for a programmable minimum width, and it lowers the enable only once the processor has released its strobe. On a write it drives the byte from the processor to the display. On a read it returns the display's byte to the processor bus, and the bus output-enable marks the cycles in which the bridge drives that bus.

Top module: `lcd_bus_bridge`

## Requirements
- R1: While reset is held and right after it is released, `lcd_e`, `bus_oe` and `lcd_doe` are 0.
- R2: An access raises `lcd_e` only when `addr_hi[7:2]` equals the window tag (default 6'b101010, which covers 0xA8 to 0xAB). An access at any other high address has no effect on `lcd_e` or `lcd_dout`.
- R3: For an accepted access, `lcd_rs` equals `addr_hi[1]` and `lcd_rw` equals `addr_hi[0]`. These give 0xA8 = instruction write (RS 0, RW 0), 0xA9 = status read (RS 0, RW 1), 0xAA = data write (RS 1, RW 0) and 0xAB = data read (RS 1, RW 1).
- R4: The strobe must match the direction bit. RW=0 needs `wr_n` low, and RW=1 needs `rd_n` low. An access with the wrong strobe is ignored: no pulse, and `lcd_dout` is unchanged.
- R5: An access with `rd_n` and `wr_n` both low is ignored: no pulse, and `lcd_dout` is unchanged.
- R6: `lcd_e` rises on the (SETUP_CYC+2)-th rising clock edge after the strobe goes low. `lcd_rs` and `lcd_rw` do not change while `lcd_e` is high.
- R7: If the strobe is held low for SETUP_CYC edges or fewer, the access is dropped and `lcd_e` stays low.
- R8: If the strobe is low for L rising edges (L > SETUP_CYC), `lcd_e` stays high for exactly max(WIDTH_CYC, L−SETUP_CYC) cycles. This is never less than WIDTH_CYC.
- R9: During a write, `lcd_doe` is high from setup until one cycle after `lcd_e` falls. When `lcd_e` falls, `lcd_dout` holds the byte the processor drove on `bus_din`.
- R10: `bus_oe` is high only during an accepted read with `rd_n` low. While it is high after the enable has risen, `bus_dout` carries the `lcd_din` byte.
- R11: `lcd_doe` is never high while `lcd_rw` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_hi | input | 8 | High byte of the processor address |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| bus_din | input | 8 | Data the processor drives during a write |
| bus_dout | output | 8 | Data returned to the processor during a read |
| bus_oe | output | 1 | Bridge drives the processor data bus |
| lcd_rs | output | 1 | Display register select |
| lcd_rw | output | 1 | Display direction, 1 = read |
| lcd_e | output | 1 | Display enable pulse |
| lcd_dout | output | 8 | Data toward the display |
| lcd_din | input | 8 | Data from the display |
| lcd_doe | output | 1 | Bridge drives the display data lines |

## Verification
The bench covers all four window addresses with both long and minimum-length strobes. Those strobe lengths separate the pulse width set by the width counter from the width stretched by a slow strobe. Negative patterns cover addresses just below and just above the window, a strobe that does not match the direction bit, both strobes low at once, and a strobe released one clock too early. Each of these shows whether the decoder, the strobe qualifier or the setup-abort path is wrong. Back-to-back writes with changing data show whether the data latch follows the current access or holds a stale byte.

// File: rtl/lcdb_pkg.sv
package lcdb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_PULSE   = 2'd2,
    ST_RECOVER = 2'd3
  } lcdb_state_e;

  typedef struct packed {
    logic rs;
    logic rw;
  } lcdb_sel_t;

  // high byte falls inside the display window
  function automatic logic win_match(input logic [7:0] a, input logic [5:0] tag);
    return a[7:2] == tag;
  endfunction

  // direction bit from the address picks which strobe must be the only low one
  function automatic logic strobe_fits(input logic rw, input logic rdn, input logic wrn);
    return rw ? (!rdn && wrn) : (!wrn && rdn);
  endfunction

  // selected strobe has been let go
  function automatic logic strobe_released(input logic rw, input logic rdn, input logic wrn);
    return rw ? rdn : wrn;
  endfunction

endpackage

// File: rtl/lcdb_sampler.sv
module lcdb_sampler #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  input  logic [DW-1:0] din_i,
  output logic [AW-1:0] addr_q,
  output logic          rd_n_q,
  output logic          wr_n_q,
  output logic [DW-1:0] din_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rd_n_q <= 1'b1;
      wr_n_q <= 1'b1;
      din_q  <= '0;
    end else begin
      addr_q <= addr_i;
      rd_n_q <= rd_n_i;
      wr_n_q <= wr_n_i;
      din_q  <= din_i;
    end
  end

endmodule

// File: rtl/lcdb_decode.sv
module lcdb_decode
  import lcdb_pkg::*;
#(
  parameter logic [5:0] WIN_TAG = 6'b101010
) (
  input  logic [7:0] addr_q,
  input  logic       rd_n_q,
  input  logic       wr_n_q,
  output logic       req,
  output logic       dual_low,
  output lcdb_sel_t  sel
);

  logic in_win;

  always_comb begin
    in_win   = win_match(addr_q, WIN_TAG);
    sel.rs   = addr_q[1];
    sel.rw   = addr_q[0];
    dual_low = !rd_n_q && !wr_n_q;
    req      = in_win && strobe_fits(sel.rw, rd_n_q, wr_n_q);
  end

endmodule

// File: rtl/lcdb_seq.sv
module lcdb_seq
  import lcdb_pkg::*;
#(
  parameter int SETUP_CYC = 3,
  parameter int WIDTH_CYC = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  lcdb_sel_t   sel_in,
  input  logic        rd_n_q,
  input  logic        wr_n_q,
  output lcdb_state_e state,
  output logic        lcd_e,
  output logic        lcd_rs,
  output logic        lcd_rw,
  output logic        ev_accept,
  output logic        ev_e_rise,
  output logic        ev_e_fall,
  output logic        ev_abort
);

  localparam int MAXC = (SETUP_CYC > WIDTH_CYC) ? SETUP_CYC : WIDTH_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] WIDTH_LAST = CW'(WIDTH_CYC - 1);

  lcdb_state_e state_n;
  logic [CW-1:0] cnt, cnt_n;
  lcdb_sel_t sel_q;
  logic held, released;

  always_comb begin
    held     = strobe_fits(sel_q.rw, rd_n_q, wr_n_q);
    released = strobe_released(sel_q.rw, rd_n_q, wr_n_q);
  end

  always_comb begin
    state_n   = state;
    cnt_n     = cnt;
    ev_accept = 1'b0;
    ev_e_rise = 1'b0;
    ev_e_fall = 1'b0;
    ev_abort  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req) begin
          ev_accept = 1'b1;
          state_n   = ST_SETUP;
          cnt_n     = '0;
        end
      end
      ST_SETUP: begin
        if (!held) begin
          ev_abort = 1'b1;
          state_n  = ST_IDLE;
        end else if (cnt == SETUP_LAST) begin
          ev_e_rise = 1'b1;
          state_n   = ST_PULSE;
          cnt_n     = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_PULSE: begin
        if (cnt >= WIDTH_LAST && released) begin
          ev_e_fall = 1'b1;
          state_n   = ST_RECOVER;
        end else if (cnt < WIDTH_LAST) begin
          cnt_n = cnt + 1'b1;
        end
      end
      default: begin
        state_n = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      sel_q <= '0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
      if (ev_accept) sel_q <= sel_in;
    end
  end

  assign lcd_e  = (state == ST_PULSE);
  assign lcd_rs = sel_q.rs;
  assign lcd_rw = sel_q.rw;

endmodule

// File: rtl/lcdb_datapath.sv
module lcdb_datapath
  import lcdb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lcdb_state_e   state,
  input  logic          rw,
  input  logic          rd_n,
  input  logic [DW-1:0] din_q,
  input  logic [DW-1:0] lcd_din,
  output logic [DW-1:0] lcd_dout,
  output logic          lcd_doe,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe
);

  logic active;
  logic [DW-1:0] wdat, rdat;

  assign active = (state == ST_SETUP) || (state == ST_PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdat <= '0;
      rdat <= '0;
    end else begin
      if (active && !rw) wdat <= din_q;
      if (state == ST_PULSE && rw) rdat <= lcd_din;
    end
  end

  assign lcd_dout = wdat;
  assign lcd_doe  = !rw && (state != ST_IDLE);
  assign bus_dout = rdat;
  assign bus_oe   = rw && active && !rd_n;

endmodule

// File: rtl/lcd_bus_bridge.sv
module lcd_bus_bridge
  import lcdb_pkg::*;
#(
  parameter int         SETUP_CYC = 3,
  parameter int         WIDTH_CYC = 5,
  parameter logic [5:0] WIN_TAG   = 6'b101010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr_hi,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [7:0] bus_din,
  output logic [7:0] bus_dout,
  output logic       bus_oe,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [7:0] lcd_dout,
  input  logic [7:0] lcd_din,
  output logic       lcd_doe
);

  localparam int DW = 8;

  logic [7:0]    s_addr;
  logic          s_rd_n, s_wr_n;
  logic [DW-1:0] s_din;
  logic          req, dual_low;
  lcdb_sel_t     sel;
  lcdb_state_e   state;
  logic          ev_accept, ev_e_rise, ev_e_fall, ev_abort;

  lcdb_sampler #(.AW(8), .DW(DW)) u_smp (
    .clk(clk), .rst_n(rst_n),
    .addr_i(addr_hi), .rd_n_i(rd_n), .wr_n_i(wr_n), .din_i(bus_din),
    .addr_q(s_addr), .rd_n_q(s_rd_n), .wr_n_q(s_wr_n), .din_q(s_din)
  );

  lcdb_decode #(.WIN_TAG(WIN_TAG)) u_dec (
    .addr_q(s_addr), .rd_n_q(s_rd_n), .wr_n_q(s_wr_n),
    .req(req), .dual_low(dual_low), .sel(sel)
  );

  lcdb_seq #(.SETUP_CYC(SETUP_CYC), .WIDTH_CYC(WIDTH_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req(req), .sel_in(sel), .rd_n_q(s_rd_n), .wr_n_q(s_wr_n),
    .state(state), .lcd_e(lcd_e), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
    .ev_accept(ev_accept), .ev_e_rise(ev_e_rise),
    .ev_e_fall(ev_e_fall), .ev_abort(ev_abort)
  );

  lcdb_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .state(state), .rw(lcd_rw), .rd_n(rd_n),
    .din_q(s_din), .lcd_din(lcd_din),
    .lcd_dout(lcd_dout), .lcd_doe(lcd_doe),
    .bus_dout(bus_dout), .bus_oe(bus_oe)
  );

endmodule

// File: rtl/lcdb_checker.sv
module lcdb_checker #(
  parameter int         SETUP_CYC = 3,
  parameter int         WIDTH_CYC = 5,
  parameter logic [5:0] WIN_TAG   = 6'b101010
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_n,
  input logic [7:0] s_addr,
  input logic       s_rd_n,
  input logic       s_wr_n,
  input logic       dual_low,
  input logic       lcd_e,
  input logic       lcd_rs,
  input logic       lcd_rw,
  input logic       bus_oe,
  input logic       lcd_doe,
  input logic       ev_accept,
  input logic       ev_e_rise,
  input logic       ev_e_fall,
  input logic       ev_abort
);

  logic [15:0] gap_cnt;
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      hi_cnt  <= '0;
    end else begin
      if (ev_accept) gap_cnt <= '0;
      else if (gap_cnt != 16'hFFFF) gap_cnt <= gap_cnt + 1'b1;
      if (!lcd_e) hi_cnt <= '0;
      else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !lcd_e && !lcd_doe); // R1
  AST_ACCEPT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> s_addr[7:2] == WIN_TAG); // R2
  AST_ACCEPT_STROBE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> (s_addr[0] ? !s_rd_n : !s_wr_n)); // R4
  AST_NO_DUAL_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> !dual_low); // R5
  AST_SETUP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_e_rise |-> gap_cnt == 16'(SETUP_CYC - 1)); // R6
  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_e |=> $stable(lcd_rs) && $stable(lcd_rw)); // R6
  AST_ABORT_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> !lcd_e); // R7
  AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_e_fall |-> hi_cnt >= 16'(WIDTH_CYC - 1)); // R8
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> lcd_rw && !rd_n); // R10
  AST_DOE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_doe |-> !lcd_rw); // R11

endmodule

bind lcd_bus_bridge lcdb_checker #(
  .SETUP_CYC(SETUP_CYC), .WIDTH_CYC(WIDTH_CYC), .WIN_TAG(WIN_TAG)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n),
  .s_addr(s_addr), .s_rd_n(s_rd_n), .s_wr_n(s_wr_n), .dual_low(dual_low),
  .lcd_e(lcd_e), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
  .bus_oe(bus_oe), .lcd_doe(lcd_doe),
  .ev_accept(ev_accept), .ev_e_rise(ev_e_rise),
  .ev_e_fall(ev_e_fall), .ev_abort(ev_abort)
);

// File: tb/lcd_bus_bridge_tb_top.sv
module lcd_bus_bridge_tb_top;

  localparam int S = 3;
  localparam int W = 5;

  typedef struct {
    logic       rs;
    logic       rw;
    logic [7:0] data;
    int         hold;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr_hi = 8'h00;
  logic       rd_n = 1'b1;
  logic       wr_n = 1'b1;
  logic [7:0] bus_din = 8'h00;
  logic [7:0] lcd_din = 8'h00;
  logic [7:0] bus_dout, lcd_dout;
  logic       bus_oe, lcd_rs, lcd_rw, lcd_e, lcd_doe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  exp_t sb[$];

  always #5 clk = ~clk;

  lcd_bus_bridge #(.SETUP_CYC(S), .WIDTH_CYC(W), .WIN_TAG(6'b101010)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .rd_n(rd_n), .wr_n(wr_n),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e),
    .lcd_dout(lcd_dout), .lcd_din(lcd_din), .lcd_doe(lcd_doe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_width(input int hold);
    return (hold - S > W) ? hold - S : W;
  endfunction

  // driver: strobe low for 'hold' rising edges, then released
  task automatic access(input logic [7:0] a, input bit use_rd, input bit use_wr,
                        input logic [7:0] d, input int hold, input bit expect_pulse);
    exp_t it;
    @(negedge clk);
    addr_hi = a;
    bus_din = d;
    lcd_din = d;
    rd_n = !use_rd;
    wr_n = !use_wr;
    if (expect_pulse) begin
      it.rs = a[1]; it.rw = a[0]; it.data = d; it.hold = hold;
      sb.push_back(it);
    end
    repeat (hold) @(negedge clk);
    if (expect_pulse && use_rd) begin
      check(bus_oe == 1'b1, "R10 oe during read", int'(bus_oe), 1);
      check(bus_dout == d, "R10 read data", int'(bus_dout), int'(d));
    end
    rd_n = 1'b1;
    wr_n = 1'b1;
    repeat (S + W + 6) @(negedge clk);
    check(bus_oe == 1'b0, "R10 oe released", int'(bus_oe), 0);
    check(lcd_e == 1'b0, "R8 enable low after access", int'(lcd_e), 0);
  endtask

  // monitor: compares each enable pulse with the expected queue
  initial begin
    bit prev_e = 1'b0;
    int low_cnt = 0;
    int hi_cnt = 0;
    exp_t cur;
    forever begin
      @(posedge clk);
      #2;
      if (rst_n) begin
        if (lcd_doe && lcd_rw) check(1'b0, "R11 doe during read", 1, 0);
        if (bus_oe && rd_n) check(1'b0, "R10 oe without rd", 1, 0);
        if (lcd_e && !prev_e) begin
          if (sb.size() == 0) begin
            check(1'b0, "R2 R4 R5 R7 unexpected enable", 1, 0);
            cur.rs = lcd_rs; cur.rw = lcd_rw; cur.data = lcd_dout; cur.hold = S + W;
          end else begin
            cur = sb[0];
            check(lcd_rs == cur.rs, "R3 rs", int'(lcd_rs), int'(cur.rs));
            check(lcd_rw == cur.rw, "R3 rw", int'(lcd_rw), int'(cur.rw));
            check(low_cnt == S + 1, "R6 setup cycles", low_cnt, S + 1);
          end
          hi_cnt = 1;
        end else if (lcd_e) begin
          hi_cnt++;
          if (lcd_rs != cur.rs || lcd_rw != cur.rw)
            check(1'b0, "R6 select moved under E", int'({lcd_rs, lcd_rw}), int'({cur.rs, cur.rw}));
        end else if (prev_e) begin
          if (sb.size() != 0) begin
            void'(sb.pop_front());
            check(hi_cnt == exp_width(cur.hold), "R8 width", hi_cnt, exp_width(cur.hold));
            if (!cur.rw) begin
              check(lcd_dout == cur.data, "R9 write data", int'(lcd_dout), int'(cur.data));
              check(lcd_doe == 1'b1, "R9 doe hold", int'(lcd_doe), 1);
            end
          end
        end
        if (!lcd_e && (!rd_n || !wr_n)) low_cnt++;
        else low_cnt = 0;
        prev_e = lcd_e;
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(lcd_e == 1'b0, "R1 e in reset", int'(lcd_e), 0);
    check(bus_oe == 1'b0, "R1 oe in reset", int'(bus_oe), 0);
    check(lcd_doe == 1'b0, "R1 doe in reset", int'(lcd_doe), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(lcd_e == 1'b0 && bus_oe == 1'b0 && lcd_doe == 1'b0, "R1 after reset",
          int'({lcd_e, bus_oe, lcd_doe}), 0);

    // R3 R6 R8 R9: instruction write, long strobe
    access(8'hA8, 1'b0, 1'b1, 8'h30, S + W + 3, 1'b1);
    // R8 minimum strobe gives minimum width
    access(8'hAA, 1'b0, 1'b1, 8'h41, S + 1, 1'b1);
    // R10 status read and data read
    access(8'hA9, 1'b1, 1'b0, 8'h80, S + W + 3, 1'b1);
    access(8'hAB, 1'b1, 1'b0, 8'h5A, S + W + 6, 1'b1);
    // R2 just below and just above the window
    access(8'hA7, 1'b0, 1'b1, 8'h77, S + W + 3, 1'b0);
    check(lcd_dout == 8'h41, "R2 dout kept below window", int'(lcd_dout), 8'h41);
    access(8'hAC, 1'b0, 1'b1, 8'h78, S + W + 3, 1'b0);
    check(lcd_dout == 8'h41, "R2 dout kept above window", int'(lcd_dout), 8'h41);
    // R4 strobe does not match the direction bit
    access(8'hA8, 1'b1, 1'b0, 8'h66, S + W + 3, 1'b0);
    access(8'hAA, 1'b1, 1'b0, 8'h67, S + W + 3, 1'b0);
    access(8'hA9, 1'b0, 1'b1, 8'h68, S + W + 3, 1'b0);
    check(lcd_dout == 8'h41, "R4 dout kept", int'(lcd_dout), 8'h41);
    // R5 both strobes low
    access(8'hAA, 1'b1, 1'b1, 8'h99, S + W + 3, 1'b0);
    check(lcd_dout == 8'h41, "R5 dout kept", int'(lcd_dout), 8'h41);
    // R7 strobe released one edge too early
    access(8'hAA, 1'b0, 1'b1, 8'h12, S, 1'b0);
    access(8'hA8, 1'b0, 1'b1, 8'h13, 1, 1'b0);
    // back-to-back data writes with changing bytes
    for (int i = 0; i < 6; i++)
      access(8'hAA, 1'b0, 1'b1, 8'(8'h20 + i * 7), S + 1 + i * 2, 1'b1);
    access(8'hA8, 1'b0, 1'b1, 8'h01, S + W + 9, 1'b1);

    repeat (10) @(negedge clk);
    check(sb.size() == 0, "R7 R8 missing enable pulses", sb.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule